// File: doc/BRIEF.md
# Extended Multiply and Effective-Address Unit

This unit executes the extension instructions that an enhanced 8-bit core adds to the classic instruction set. These are an unsigned byte-by-byte multiply on the two halves of a register pair, an index-plus-displacement address calculation whose result goes either to a register pair or to the stack, a flag-only test of the accumulator, and moves between the memory-base register and the accumulator. The decoder supplies an operation code and the relevant register values. The unit returns a result word, a code that tells the register file where the word goes, and the new flags byte.

The unit is one pipeline stage. Operands are sampled on the clock edge where `in_valid` is high, and the result appears on the outputs one cycle later with `out_valid` high. It never touches memory. For the memory-operand test, the caller fetches the byte addressed by HL and presents it on `mem_byte`. For the push form, the caller performs the stack write using the value the unit returns. Address arithmetic wraps at 16 bits in short data mode and at 24 bits in long data mode.

Top module: `xu_ext_unit`

## Requirements
- R1: Operation code 1 (multiply) returns the high byte of the selected pair times its low byte, unsigned, as a 16-bit product in `result[15:0]` with `result[23:16]` zero. The destination is that pair.
- R2: `pair_sel` selects 0 = BC, 1 = DE, 2 = HL, 3 = SP. The destination codes on `dest_sel` are 0 none, 1 BC, 2 DE, 3 HL, 4 SP, 5 accumulator, 6 memory base, 7 push.
- R3: Operation code 2 (address load) returns the index register (`idx_sel` 0 = IX, 1 = IY) plus the sign-extended `disp`. The destination is the pair chosen by `pair_sel`.
- R4: When `long_mode` is 0, address results keep only the low 16 bits, with `result[23:16]` zero, so they wrap modulo 65536.
- R5: When `long_mode` is 1, address results use all 24 bits and wrap modulo 2^24.
- R6: Operation code 3 (address push) returns the same sum as R3, and its destination code is 7 (push).
- R7: Operation codes 4 and 5 (test) return destination 0 and `result` equal to the accumulator. The flags are set as follows: bit7 = bit 7 of (A AND operand), bit6 = 1 if that AND is zero, bit4 = 1, bit2 = 1 on even parity of the AND, and bit1 = 0, bit0 = 0. Bits 5 and 3 are copied from `flags_in`.
- R8: Operation code 4 tests A against itself. Operation code 5 tests A against `mem_byte`.
- R9: Operation code 6 returns `base_reg` with destination 5. Operation code 7 returns `acc` with destination 6.
- R10: Every operation other than the test operations returns `flags_out` equal to `flags_in`. Operation code 0 returns destination 0 and result 0.
- R11: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is 0, the other outputs hold their values. A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation code (see R1, R3, R6 to R10) |
| pair_sel | input | 2 | Register pair for multiply source and address-load destination |
| idx_sel | input | 1 | Index source: 0 IX, 1 IY |
| long_mode | input | 1 | Data mode: 0 short (16-bit), 1 long (24-bit) |
| disp | input | 8 | Signed displacement |
| acc | input | 8 | Accumulator |
| base_reg | input | 8 | Memory-base register |
| mem_byte | input | 8 | Byte addressed by HL, fetched by caller |
| flags_in | input | 8 | Current flags |
| pair_bc | input | 16 | Low 16 bits of BC |
| pair_de | input | 16 | Low 16 bits of DE |
| pair_hl | input | 16 | Low 16 bits of HL |
| pair_sp | input | 16 | Low 16 bits of the active stack pointer |
| reg_ix | input | 24 | IX |
| reg_iy | input | 24 | IY |
| out_valid | output | 1 | Result valid |
| result | output | 24 | Result value |
| dest_sel | output | 3 | Destination code (R2) |
| flags_out | output | 8 | New flags |

## Verification
The bench instantiates the unit with `MUL_SHIFT_ADD` set to 1. This elaborates the generated shift-and-add partial-product chain instead of the default operator form, so the full-scale product 0xFF times 0xFF and the zero and one operands exercise every stage of that chain. The address width stays at 24 and the short width at 16. As a result, negative displacements that cross zero wrap in both modes, and a carry out of bit 15 is either discarded or kept depending on the data mode.

// File: rtl/xu_pkg.sv
// Package xu_pkg: operation codes, destination codes and flag bit
// positions shared by the extended-instruction unit and its bench.
package xu_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_MUL      = 3'd1,
        OP_ADDR_LD  = 3'd2,
        OP_ADDR_PSH = 3'd3,
        OP_TST_A    = 3'd4,
        OP_TST_MEM  = 3'd5,
        OP_BASE_TO_A = 3'd6,
        OP_A_TO_BASE = 3'd7
    } op_t;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_BC   = 3'd1,
        DST_DE   = 3'd2,
        DST_HL   = 3'd3,
        DST_SP   = 3'd4,
        DST_ACC  = 3'd5,
        DST_BASE = 3'd6,
        DST_PUSH = 3'd7
    } dst_t;

    localparam int FLG_C  = 0;
    localparam int FLG_N  = 1;
    localparam int FLG_PV = 2;
    localparam int FLG_X  = 3;
    localparam int FLG_H  = 4;
    localparam int FLG_Y  = 5;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 7;

endpackage

// File: rtl/xu_mul_byte.sv
// Module xu_mul_byte: unsigned BYTE_W x BYTE_W multiplier, purely combinational.
// Assumes both operands are unsigned. MUL_SHIFT_ADD selects an explicit
// generated chain of shifted partial products instead of the '*' operator.
module xu_mul_byte #(
    parameter int BYTE_W        = 8,
    parameter bit MUL_SHIFT_ADD = 1'b0
) (
    input  logic [BYTE_W-1:0]   op_hi,
    input  logic [BYTE_W-1:0]   op_lo,
    output logic [2*BYTE_W-1:0] product
);
    localparam int PROD_W = 2 * BYTE_W;

    generate
        if (MUL_SHIFT_ADD) begin : g_shift_add
            logic [PROD_W-1:0] partial [BYTE_W+1];
            logic [PROD_W-1:0] hi_ext;

            // Zero-extend the multiplicand to product width
            assign hi_ext = {{BYTE_W{1'b0}}, op_hi};
            assign partial[0] = '0;

            for (genvar i = 0; i < BYTE_W; i++) begin : g_stage
                // Add the shifted multiplicand when multiplier bit i is set
                assign partial[i+1] = partial[i] + (op_lo[i] ? (hi_ext << i) : '0);
            end

            assign product = partial[BYTE_W];
        end else begin : g_operator
            // Direct operator form, left to synthesis to map
            assign product = PROD_W'(op_hi) * PROD_W'(op_lo);
        end
    endgenerate

endmodule

// File: rtl/xu_ea_adder.sv
// Module xu_ea_adder: index plus signed displacement, masked by data mode.
// Assumes disp is two's complement; in short mode the upper bits of the
// sum are cleared so the result wraps at 2**SHORT_W.
module xu_ea_adder #(
    parameter int ADDR_W  = 24,
    parameter int SHORT_W = 16,
    parameter int DISP_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic              long_mode,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - DISP_W;
    localparam int HI_W  = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sum;

    // Sign-extend the displacement to the address width
    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    // Full-width modular sum
    assign sum = base + disp_ext;

    // Apply the data-mode mask to the sum
    always_comb begin
        if (long_mode) addr = sum;
        else           addr = {{HI_W{1'b0}}, sum[SHORT_W-1:0]};
    end

endmodule

// File: rtl/xu_test_flags.sv
// Module xu_test_flags: flag generation for the AND-based test operation.
// Assumes operand is already chosen (A or the fetched byte); the two
// undocumented flag bits are carried over from the incoming flags.
module xu_test_flags #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] operand,
    input  logic [7:0]        flags_in,
    output logic [7:0]        flags_out
);
    import xu_pkg::*;

    logic [BYTE_W-1:0] masked;

    // Logical AND that the flags describe; A itself is not written
    assign masked = acc & operand;

    // Assemble the flags byte from the AND result
    always_comb begin
        flags_out         = flags_in;
        flags_out[FLG_S]  = masked[BYTE_W-1];
        flags_out[FLG_Z]  = (masked == '0);
        flags_out[FLG_H]  = 1'b1;
        flags_out[FLG_PV] = ~^masked;
        flags_out[FLG_N]  = 1'b0;
        flags_out[FLG_C]  = 1'b0;
    end

endmodule

// File: rtl/xu_ext_unit.sv
// Module xu_ext_unit: one-stage execution unit for the extended instructions
// (pair multiply, index+displacement address load/push, flag test, base
// register moves). Assumes the decoder supplies the active stack pointer on
// pair_sp and the HL-addressed byte on mem_byte. Outputs register on in_valid.
module xu_ext_unit #(
    parameter int ADDR_W        = 24,
    parameter int SHORT_W       = 16,
    parameter int BYTE_W        = 8,
    parameter bit MUL_SHIFT_ADD = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op_code,
    input  logic [1:0]          pair_sel,
    input  logic                idx_sel,
    input  logic                long_mode,
    input  logic [BYTE_W-1:0]   disp,
    input  logic [BYTE_W-1:0]   acc,
    input  logic [BYTE_W-1:0]   base_reg,
    input  logic [BYTE_W-1:0]   mem_byte,
    input  logic [7:0]          flags_in,
    input  logic [2*BYTE_W-1:0] pair_bc,
    input  logic [2*BYTE_W-1:0] pair_de,
    input  logic [2*BYTE_W-1:0] pair_hl,
    input  logic [2*BYTE_W-1:0] pair_sp,
    input  logic [ADDR_W-1:0]   reg_ix,
    input  logic [ADDR_W-1:0]   reg_iy,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   result,
    output logic [2:0]          dest_sel,
    output logic [7:0]          flags_out
);
    import xu_pkg::*;

    localparam int PAIR_W  = 2 * BYTE_W;
    localparam int PROD_PAD = ADDR_W - PAIR_W;
    localparam int BYTE_PAD = ADDR_W - BYTE_W;

    op_t                op;
    logic [PAIR_W-1:0]  pair_val;
    logic [PAIR_W-1:0]  product;
    logic [ADDR_W-1:0]  idx_val;
    logic [ADDR_W-1:0]  ea;
    logic [BYTE_W-1:0]  tst_operand;
    logic [7:0]         tst_flags;
    dst_t               pair_dst;
    logic [ADDR_W-1:0]  nxt_result;
    dst_t               nxt_dest;
    logic [7:0]         nxt_flags;

    assign op = op_t'(op_code);

    // Select the multiply source pair
    always_comb begin
        case (pair_sel)
            2'd0:    pair_val = pair_bc;
            2'd1:    pair_val = pair_de;
            2'd2:    pair_val = pair_hl;
            default: pair_val = pair_sp;
        endcase
    end

    // Destination code of the selected pair
    assign pair_dst = dst_t'({1'b0, pair_sel} + 3'd1);

    // Select the index source for address arithmetic
    assign idx_val = idx_sel ? reg_iy : reg_ix;

    // Select the test operand: A itself or the fetched byte
    assign tst_operand = (op == OP_TST_MEM) ? mem_byte : acc;

    xu_mul_byte #(
        .BYTE_W        (BYTE_W),
        .MUL_SHIFT_ADD (MUL_SHIFT_ADD)
    ) u_mul (
        .op_hi   (pair_val[PAIR_W-1:BYTE_W]),
        .op_lo   (pair_val[BYTE_W-1:0]),
        .product (product)
    );

    xu_ea_adder #(
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W),
        .DISP_W  (BYTE_W)
    ) u_ea (
        .base      (idx_val),
        .disp      (disp),
        .long_mode (long_mode),
        .addr      (ea)
    );

    xu_test_flags #(
        .BYTE_W (BYTE_W)
    ) u_tst (
        .acc       (acc),
        .operand   (tst_operand),
        .flags_in  (flags_in),
        .flags_out (tst_flags)
    );

    // Decode the operation into result, destination and flags
    always_comb begin
        nxt_result = '0;
        nxt_dest   = DST_NONE;
        nxt_flags  = flags_in;
        case (op)
            OP_MUL: begin
                nxt_result = {{PROD_PAD{1'b0}}, product};
                nxt_dest   = pair_dst;
            end
            OP_ADDR_LD: begin
                nxt_result = ea;
                nxt_dest   = pair_dst;
            end
            OP_ADDR_PSH: begin
                nxt_result = ea;
                nxt_dest   = DST_PUSH;
            end
            OP_TST_A, OP_TST_MEM: begin
                nxt_result = {{BYTE_PAD{1'b0}}, acc};
                nxt_flags  = tst_flags;
            end
            OP_BASE_TO_A: begin
                nxt_result = {{BYTE_PAD{1'b0}}, base_reg};
                nxt_dest   = DST_ACC;
            end
            OP_A_TO_BASE: begin
                nxt_result = {{BYTE_PAD{1'b0}}, acc};
                nxt_dest   = DST_BASE;
            end
            default: ;
        endcase
    end

    // Output register stage, updated only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            dest_sel  <= DST_NONE;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt_result;
                dest_sel  <= nxt_dest;
                flags_out <= nxt_flags;
            end
        end
    end

    AST_MUL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 3'd1) |=> (result[ADDR_W-1:PAIR_W] == '0 && dest_sel == {1'b0, $past(pair_sel)} + 3'd1)); // R1

    AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 3'd2 || op_code == 3'd3) && !long_mode) |=> (result[ADDR_W-1:SHORT_W] == '0)); // R4

    AST_PUSH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 3'd3) |=> (dest_sel == 3'd7)); // R6

    AST_TST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 3'd4 || op_code == 3'd5)) |=> (flags_out[4] && !flags_out[1] && !flags_out[0] && dest_sel == 3'd0)); // R7

    AST_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code != 3'd4 && op_code != 3'd5) |=> (flags_out == $past(flags_in))); // R10

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(dest_sel) && $stable(flags_out))); // R11

endmodule

// File: tb/sim_xu_ext_unit.sv
// Directed bench for xu_ext_unit: one task per scenario, expected values
// computed from the requirements.
module sim_xu_ext_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  pair_sel = '0;
    logic        idx_sel = 1'b0;
    logic        long_mode = 1'b0;
    logic [7:0]  disp = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  base_reg = '0;
    logic [7:0]  mem_byte = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] pair_bc = '0;
    logic [15:0] pair_de = '0;
    logic [15:0] pair_hl = '0;
    logic [15:0] pair_sp = '0;
    logic [23:0] reg_ix = '0;
    logic [23:0] reg_iy = '0;
    logic        out_valid;
    logic [23:0] result;
    logic [2:0]  dest_sel;
    logic [7:0]  flags_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    xu_ext_unit #(.MUL_SHIFT_ADD(1'b1)) u0 (
        .clk, .rst_n, .in_valid, .op_code, .pair_sel, .idx_sel, .long_mode,
        .disp, .acc, .base_reg, .mem_byte, .flags_in,
        .pair_bc, .pair_de, .pair_hl, .pair_sp, .reg_ix, .reg_iy,
        .out_valid, .result, .dest_sel, .flags_out
    );

    task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one request, return after outputs settle past the capture edge
    task automatic issue(input logic [2:0] op);
        @(negedge clk);
        op_code  = op;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
        op_code  = 3'd0;
    endtask

    task automatic expect_out(input string req, input logic [23:0] r, input logic [2:0] d, input logic [7:0] f);
        chk(req, "out_valid", {23'd0, out_valid}, 24'd1);
        chk(req, "result",    result,   r);
        chk(req, "dest_sel",  {21'd0, dest_sel}, {21'd0, d});
        chk(req, "flags_out", {16'd0, flags_out}, {16'd0, f});
    endtask

    function automatic logic [23:0] ea_model(input logic [23:0] b, input logic [7:0] d, input logic lm);
        int s;
        s = int'(b) + int'($signed(d));
        return lm ? 24'(s) : {8'd0, 16'(s)};
    endfunction

    function automatic logic [7:0] tst_model(input logic [7:0] a, input logic [7:0] o, input logic [7:0] fi);
        logic [7:0] m;
        logic [7:0] f;
        int ones;
        m = a & o;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(m[i]);
        f = 8'h00;
        f[7] = m[7];
        f[6] = (m == 8'h00);
        f[5] = fi[5];
        f[4] = 1'b1;
        f[3] = fi[3];
        f[2] = (ones % 2 == 0);
        return f;
    endfunction

    task automatic t_reset();
        chk("R11", "reset out_valid", {23'd0, out_valid}, 24'd0);
        chk("R11", "reset result", result, 24'd0);
        chk("R11", "reset dest", {21'd0, dest_sel}, 24'd0);
        chk("R11", "reset flags", {16'd0, flags_out}, 24'd0);
    endtask

    task automatic t_mul();
        logic [7:0] hv [4] = '{8'h12, 8'hFF, 8'h00, 8'h01};
        logic [7:0] lv [4] = '{8'h34, 8'hFF, 8'h9A, 8'hC7};
        flags_in = 8'hA5;
        for (int p = 0; p < 4; p++) begin
            pair_bc = 16'h0000; pair_de = 16'h0000; pair_hl = 16'h0000; pair_sp = 16'h0000;
            case (p)
                0: pair_bc = {hv[p], lv[p]};
                1: pair_de = {hv[p], lv[p]};
                2: pair_hl = {hv[p], lv[p]};
                default: pair_sp = {hv[p], lv[p]};
            endcase
            pair_sel = 2'(p);
            issue(3'd1);
            // R1 product; R2 pair code p maps to dest p+1
            expect_out("R1", {8'd0, 16'(hv[p]) * 16'(lv[p])}, 3'(p + 1), 8'hA5);
        end
        pair_sel = 2'd2; pair_hl = 16'hFFFF;
        issue(3'd1);
        expect_out("R2", 24'h00FE01, 3'd3, 8'hA5);
    endtask

    task automatic t_addr_load();
        flags_in = 8'h3C;
        reg_ix = 24'hD10010; reg_iy = 24'h000003;
        // Positive displacement, long mode, IX into HL
        idx_sel = 1'b0; long_mode = 1'b1; disp = 8'h0A; pair_sel = 2'd2;
        issue(3'd2);
        expect_out("R3", ea_model(24'hD10010, 8'h0A, 1'b1), 3'd3, 8'h3C);
        // Negative displacement, short mode, IX into DE: upper byte cleared
        idx_sel = 1'b0; long_mode = 1'b0; disp = 8'hFB; pair_sel = 2'd1;
        issue(3'd2);
        expect_out("R4", 24'h00000B, 3'd2, 8'h3C);
        // Short mode wrap below zero from IY
        idx_sel = 1'b1; long_mode = 1'b0; disp = 8'hF0; pair_sel = 2'd0;
        issue(3'd2);
        expect_out("R4", 24'h00FFF3, 3'd1, 8'h3C);
        // Long mode wrap below zero from IY
        long_mode = 1'b1;
        issue(3'd2);
        expect_out("R5", 24'hFFFFF3, 3'd1, 8'h3C);
        // Short mode carry out of bit 15 discarded vs kept in long mode
        reg_ix = 24'h12FFF8; idx_sel = 1'b0; disp = 8'h7F; pair_sel = 2'd3;
        long_mode = 1'b0;
        issue(3'd2);
        expect_out("R4", 24'h000077, 3'd4, 8'h3C);
        long_mode = 1'b1;
        issue(3'd2);
        expect_out("R5", 24'h130077, 3'd4, 8'h3C);
    endtask

    task automatic t_addr_push();
        flags_in = 8'h81;
        reg_iy = 24'h00ABCD; idx_sel = 1'b1; disp = 8'h80; long_mode = 1'b1; pair_sel = 2'd0;
        issue(3'd3);
        expect_out("R6", ea_model(24'h00ABCD, 8'h80, 1'b1), 3'd7, 8'h81);
        reg_iy = 24'hFFFFFF; disp = 8'h02; long_mode = 1'b0;
        issue(3'd3);
        expect_out("R6", 24'h000001, 3'd7, 8'h81);
    endtask

    task automatic t_test();
        // Test A with itself, zero result, X/Y preserved
        flags_in = 8'hFF; acc = 8'h00;
        issue(3'd4);
        expect_out("R7", 24'h000000, 3'd0, tst_model(8'h00, 8'h00, 8'hFF));
        // Sign set, odd parity
        flags_in = 8'h00; acc = 8'h80;
        issue(3'd4);
        expect_out("R8", 24'h000080, 3'd0, tst_model(8'h80, 8'h80, 8'h00));
        // Memory operand, even parity, nonzero
        acc = 8'hF0; mem_byte = 8'h3C; flags_in = 8'h28;
        issue(3'd5);
        expect_out("R8", 24'h0000F0, 3'd0, 8'h3C);
        // Memory operand disjoint from A gives zero
        acc = 8'h0F; mem_byte = 8'hF0; flags_in = 8'h03;
        issue(3'd5);
        expect_out("R7", 24'h00000F, 3'd0, 8'h54);
    endtask

    task automatic t_moves();
        flags_in = 8'h5A; base_reg = 8'hD0; acc = 8'h37;
        issue(3'd6);
        expect_out("R9", 24'h0000D0, 3'd5, 8'h5A);
        issue(3'd7);
        expect_out("R9", 24'h000037, 3'd6, 8'h5A);
    endtask

    task automatic t_nop();
        flags_in = 8'hC3;
        issue(3'd0);
        expect_out("R10", 24'h000000, 3'd0, 8'hC3);
    endtask

    task automatic t_idle_hold();
        // Known output from a move, then change inputs with in_valid low
        base_reg = 8'h44; flags_in = 8'h11;
        issue(3'd6);
        @(negedge clk);
        base_reg = 8'h99; flags_in = 8'hEE; acc = 8'h01; op_code = 3'd7;
        @(posedge clk); #1;
        chk("R11", "idle out_valid", {23'd0, out_valid}, 24'd0);
        chk("R11", "idle result", result, 24'h000044);
        chk("R11", "idle dest", {21'd0, dest_sel}, 24'd5);
        chk("R11", "idle flags", {16'd0, flags_out}, 24'h000011);
        op_code = 3'd0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_mul();
        t_addr_load();
        t_addr_push();
        t_test();
        t_moves();
        t_nop();
        t_idle_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule